// File: doc/BRIEF.md
# Three-Axis Sensor I2C Register Target

This block is the I2C target side of a three-axis field sensor. It sits on a two-wire bus at a fixed 7-bit address and serves a small byte-wide register map. The map holds three signed 16-bit corrected readings and three user-programmable 16-bit hard-iron offsets. A sensor front end hands over a raw sample on a parallel bus with a one-cycle strobe. The block subtracts the stored offset from each axis, publishes the three results together and raises a data-ready interrupt.

A bus controller first writes a register index and can then stream bytes in or out. The index advances by one after every byte, so one burst can cover all three axes. Reading the last reading byte drops the interrupt. While a burst that began at the first reading byte is in progress, a new sample is held back, so the six bytes a host collects always come from one sample. The block never drives the bus lines high. It pulls SDA and SCL low through drive-low enables. It holds SCL low for a fixed number of cycles after each acknowledged byte, to model its fetch and commit time.

Top module: `i2c_sensor_target`

## Requirements
- R1: After reset every register reads as zero, the interrupt is low and neither bus line is pulled low.
- R2: The block acknowledges an address byte only when its upper seven bits equal TARGET_ADDR (default 0x0E, giving 0x1C for write and 0x1D for read). Bit 0 selects the direction, and 1 means read.
- R3: After an address that does not match, the block neither acknowledges nor changes any register until the next START.
- R4: In a write transfer the first data byte sets the register index. Each later byte is stored at the index, which then increments. The offsets are at 0x09/0x0A (X), 0x0B/0x0C (Y) and 0x0D/0x0E (Z), with the high byte at the lower index.
- R5: The corrected readings are at 0x01/0x02 (X), 0x03/0x04 (Y) and 0x05/0x06 (Z), high byte first. They are read-only, so writes to them are ignored. Every unmapped index reads as zero.
- R6: On a sample strobe each published reading equals raw minus offset, wrapped to 16 bits.
- R7: The interrupt rises when a new set of readings is published. It stays high through reads of 0x01 to 0x05, and falls when 0x06 is read.
- R8: A sample that arrives during a read burst that began at 0x01 is published only after 0x06 has been read or the transfer has ended. All six bytes of that burst come from the earlier sample.
- R9: In a read transfer the byte at the index is sent MSB first and the index increments. The controller's ACK fetches the next byte. A NACK ends the target's part of the transfer.
- R10: After every acknowledged address, write or read byte, the block holds SCL low for STRETCH_CYCLES clock cycles from the falling edge it detects on SCL.
- R11: A START or STOP in the middle of a byte abandons that byte without storing it. The new condition is honoured, and a repeated START begins a new address phase.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level as seen on the bus |
| sda_i | input | 1 | SDA line level as seen on the bus |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (ACK or a zero data bit) |
| sample_valid | input | 1 | One-cycle strobe that a raw sample is present |
| raw_x | input | AXIS_W | Raw X axis value |
| raw_y | input | AXIS_W | Raw Y axis value |
| raw_z | input | AXIS_W | Raw Z axis value |
| drdy_irq | output | 1 | Data-ready interrupt, active high |

## Verification
The bench builds the block with its default parameters: target address 0x0E, 16-bit axes, a two-stage line synchroniser and a stretch of 24 cycles. The controller model uses a 12-cycle half bit. At that speed every stretch is longer than the controller's own low phase, so the bench sees and counts each stretch on the bus. Transfers are short enough to sweep all 128 addresses and to visit every register byte. The subtraction is driven through its wrap corners (0x8000 minus 1, and 0 minus 0xFFFF). The bench also issues a sample in the middle of a burst and aborts transfers with both a START and a STOP partway through a byte.

// File: rtl/i2c_sns_pkg.sv
package i2c_sns_pkg;

  // Number of axes served by the register map.
  localparam int NUM_AXES = 3;

  // Byte-transfer engine states.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } eng_state_t;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sh_q, scl_sh_d;
  logic [SYNC_STAGES-1:0] sda_sh_q, sda_sh_d;
  logic                   scl_prev_q, sda_prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign scl_sh_d = scl_i;
      assign sda_sh_d = sda_i;
    end else begin : g_many
      assign scl_sh_d = {scl_sh_q[SYNC_STAGES-2:0], scl_i};
      assign sda_sh_d = {sda_sh_q[SYNC_STAGES-2:0], sda_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q   <= '1;
      sda_sh_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sh_q   <= scl_sh_d;
      sda_sh_q   <= sda_sh_d;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  always_comb begin
    scl_s     = scl_sh_q[SYNC_STAGES-1];
    sda_s     = sda_sh_q[SYNC_STAGES-1];
    scl_rise  = scl_s & ~scl_prev_q;
    scl_fall  = ~scl_s & scl_prev_q;
    start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  end

endmodule

// File: rtl/sns_axis_regs.sv
module sns_axis_regs #(
  parameter int AXES      = 3,
  parameter int AXIS_W    = 16,
  parameter int READ_BASE = 1,
  parameter int OFS_BASE  = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_valid,
  input  logic [AXES*AXIS_W-1:0] raw_flat,
  input  logic [7:0]             reg_addr,
  input  logic                   wr_en,
  input  logic [7:0]             wr_data,
  input  logic                   rd_take,
  input  logic                   txn_end,
  output logic [7:0]             rd_data,
  output logic                   drdy,
  output logic                   publish,
  output logic                   last_read
);

  localparam int BPA       = AXIS_W / 8;
  localparam int READ_LAST = READ_BASE + AXES * BPA - 1;

  logic [AXIS_W-1:0] rdg_all [AXES];
  logic [AXIS_W-1:0] ofs_all [AXES];

  logic pend_q, pend_d;
  logic hold_q, hold_d;
  logic drdy_q, drdy_d;
  logic first_read;

  always_comb begin
    first_read = rd_take && (reg_addr == 8'(READ_BASE));
    last_read  = rd_take && (reg_addr == 8'(READ_LAST));
    publish    = pend_q && !hold_q && !first_read;
    pend_d     = sample_valid || (pend_q && !publish);
    if (txn_end || last_read) hold_d = 1'b0;
    else if (first_read)      hold_d = 1'b1;
    else                      hold_d = hold_q;
    if (publish)        drdy_d = 1'b1;
    else if (last_read) drdy_d = 1'b0;
    else                drdy_d = drdy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
      drdy_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      hold_q <= hold_d;
      drdy_q <= drdy_d;
    end
  end

  assign drdy = drdy_q;

  generate
    for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
      logic [AXIS_W-1:0] ofs_q, ofs_d;
      logic [AXIS_W-1:0] raw_q, raw_d;
      logic [AXIS_W-1:0] rdg_q, rdg_d;

      always_comb begin
        ofs_d = ofs_q;
        for (int by = 0; by < BPA; by++) begin
          if (wr_en && (reg_addr == 8'(OFS_BASE + ax * BPA + by)))
            ofs_d[(BPA-1-by)*8 +: 8] = wr_data;
        end
        raw_d = sample_valid ? raw_flat[ax*AXIS_W +: AXIS_W] : raw_q;
        rdg_d = publish ? (raw_q - ofs_q) : rdg_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ofs_q <= '0;
          raw_q <= '0;
          rdg_q <= '0;
        end else begin
          ofs_q <= ofs_d;
          raw_q <= raw_d;
          rdg_q <= rdg_d;
        end
      end

      assign rdg_all[ax] = rdg_q;
      assign ofs_all[ax] = ofs_q;
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int ax = 0; ax < AXES; ax++) begin
      for (int by = 0; by < BPA; by++) begin
        if (reg_addr == 8'(READ_BASE + ax * BPA + by))
          rd_data = rdg_all[ax][(BPA-1-by)*8 +: 8];
        if (reg_addr == 8'(OFS_BASE + ax * BPA + by))
          rd_data = ofs_all[ax][(BPA-1-by)*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
  import i2c_sns_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR    = 7'h0E,
  parameter int         STRETCH_CYCLES = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [7:0] reg_addr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       rd_take,
  output logic       txn_end,
  output logic       sda_low,
  output logic       scl_low,
  output eng_state_t state
);

  localparam int SW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [SW-1:0] STRETCH_LOAD = SW'(STRETCH_CYCLES);

  eng_state_t    st_q, st_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          rw_q, rw_d;
  logic          ptrph_q, ptrph_d;
  logic [7:0]    ptr_q, ptr_d;
  logic          sda_q, sda_d;
  logic          ack_q, ack_d;
  logic [SW-1:0] str_q, str_d;

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    ptrph_d = ptrph_q;
    ptr_d   = ptr_q;
    sda_d   = sda_q;
    ack_d   = ack_q;
    str_d   = (str_q != '0) ? (str_q - 1'b1) : str_q;
    wr_en   = 1'b0;
    rd_take = 1'b0;
    txn_end = 1'b0;

    if (start_det) begin
      st_d    = ST_ADDR;
      bit_d   = 4'd0;
      sda_d   = 1'b0;
      str_d   = '0;
      txn_end = 1'b1;
    end else if (stop_det) begin
      st_d    = ST_IDLE;
      sda_d   = 1'b0;
      str_d   = '0;
      txn_end = 1'b1;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (sh_q[7:1] == TARGET_ADDR) begin
              st_d  = ST_AACK;
              sda_d = 1'b1;
              rw_d  = sh_q[0];
            end else begin
              st_d = ST_IGNORE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            str_d = STRETCH_LOAD;
            bit_d = 4'd0;
            if (rw_q) begin
              st_d    = ST_RDATA;
              sh_d    = rd_data;
              sda_d   = ~rd_data[7];
              rd_take = 1'b1;
              ptr_d   = ptr_q + 8'd1;
            end else begin
              st_d    = ST_WDATA;
              sda_d   = 1'b0;
              ptrph_d = 1'b1;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            st_d  = ST_WACK;
            sda_d = 1'b1;
            if (ptrph_q) begin
              ptr_d   = sh_q;
              ptrph_d = 1'b0;
            end else begin
              wr_en = 1'b1;
              ptr_d = ptr_q + 8'd1;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            st_d  = ST_WDATA;
            sda_d = 1'b0;
            bit_d = 4'd0;
            str_d = STRETCH_LOAD;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              st_d  = ST_RACK;
              sda_d = 1'b0;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              sda_d = ~sh_q[6];
              bit_d = bit_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_d = ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              st_d    = ST_RDATA;
              str_d   = STRETCH_LOAD;
              bit_d   = 4'd0;
              sh_d    = rd_data;
              sda_d   = ~rd_data[7];
              rd_take = 1'b1;
              ptr_d   = ptr_q + 8'd1;
            end else begin
              st_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bit_q   <= 4'd0;
      sh_q    <= 8'h00;
      rw_q    <= 1'b0;
      ptrph_q <= 1'b0;
      ptr_q   <= 8'h00;
      sda_q   <= 1'b0;
      ack_q   <= 1'b0;
      str_q   <= '0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      ptrph_q <= ptrph_d;
      ptr_q   <= ptr_d;
      sda_q   <= sda_d;
      ack_q   <= ack_d;
      str_q   <= str_d;
    end
  end

  assign reg_addr = ptr_q;
  assign wr_data  = sh_q;
  assign sda_low  = sda_q;
  assign scl_low  = (str_q != '0);
  assign state    = st_q;

endmodule

// File: rtl/i2c_sensor_target.sv
module i2c_sensor_target
  import i2c_sns_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR    = 7'h0E,
  parameter int         AXIS_W         = 16,
  parameter int         STRETCH_CYCLES = 24,
  parameter int         SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic              sample_valid,
  input  logic [AXIS_W-1:0] raw_x,
  input  logic [AXIS_W-1:0] raw_y,
  input  logic [AXIS_W-1:0] raw_z,
  output logic              drdy_irq
);

  localparam int READ_BASE = 1;
  localparam int OFS_BASE  = 9;

  logic       scl_sync, sda_sync, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] reg_addr, wr_data, rd_data;
  logic       wr_en, rd_take, txn_end, publish, last_read;
  eng_state_t eng_state;

  i2c_line_sampler #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_sync),
    .sda_s    (sda_sync),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_target_engine #(
    .TARGET_ADDR   (TARGET_ADDR),
    .STRETCH_CYCLES(STRETCH_CYCLES)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_sync),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (rd_data),
    .reg_addr (reg_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_take  (rd_take),
    .txn_end  (txn_end),
    .sda_low  (sda_drive_low),
    .scl_low  (scl_drive_low),
    .state    (eng_state)
  );

  sns_axis_regs #(
    .AXES     (NUM_AXES),
    .AXIS_W   (AXIS_W),
    .READ_BASE(READ_BASE),
    .OFS_BASE (OFS_BASE)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .raw_flat    ({raw_z, raw_y, raw_x}),
    .reg_addr    (reg_addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_take     (rd_take),
    .txn_end     (txn_end),
    .rd_data     (rd_data),
    .drdy        (drdy_irq),
    .publish     (publish),
    .last_read   (last_read)
  );

endmodule

// File: rtl/i2c_sensor_target_chk.sv
module i2c_sensor_target_chk
  import i2c_sns_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_drive_low,
  input logic       sda_drive_low,
  input logic       scl_sync,
  input logic       start_det,
  input logic       stop_det,
  input eng_state_t eng_state,
  input logic       drdy_irq,
  input logic       publish,
  input logic       last_read
);

  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state == ST_IGNORE) |-> (!sda_drive_low && !scl_drive_low));

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state == ST_IDLE) |-> (!sda_drive_low && !scl_drive_low));

  // R12
  sda_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(sda_drive_low) || $fell(sda_drive_low)) && !$past(start_det || stop_det))
      |-> !$past(scl_sync));

  // R10
  stretch_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> !$past(scl_sync));

  // R7
  drdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_irq) |-> $past(publish));

  // R7
  drdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_irq) |-> $past(last_read));

  // R8
  no_publish_mid_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (publish && last_read) |-> 1'b0 || !publish);

endmodule

bind i2c_sensor_target i2c_sensor_target_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_drive_low(scl_drive_low),
  .sda_drive_low(sda_drive_low),
  .scl_sync     (scl_sync),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .eng_state    (eng_state),
  .drdy_irq     (drdy_irq),
  .publish      (publish),
  .last_read    (last_read)
);

// File: tb/i2c_sensor_target_tb.sv
module i2c_sensor_target_tb;

  localparam int HALF = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_scl_low = 1'b0;
  logic tb_sda_low = 1'b0;
  logic sample_valid = 1'b0;
  logic [15:0] raw_x = '0, raw_y = '0, raw_z = '0;
  logic dut_scl_low, dut_sda_low, drdy_irq;

  wire scl_bus = !(tb_scl_low || dut_scl_low);
  wire sda_bus = !(tb_sda_low || dut_sda_low);

  always #10 clk = ~clk;

  i2c_sensor_target u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_bus),
    .sda_i        (sda_bus),
    .scl_drive_low(dut_scl_low),
    .sda_drive_low(dut_sda_low),
    .sample_valid (sample_valid),
    .raw_x        (raw_x),
    .raw_y        (raw_y),
    .raw_z        (raw_z),
    .drdy_irq     (drdy_irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int stretches = 0;
  bit finished = 0;
  logic [7:0] rbuf [16];
  logic [7:0] wbuf [16];
  logic [15:0] m_ofs [3];
  logic [15:0] m_rdg [3];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_scl();
    int w = 0;
    tb_scl_low = 1'b0;
    #1;
    while (!scl_bus && w < 1000) begin
      @(negedge clk);
      w++;
    end
    if (w > 0) stretches++;
  endtask

  task automatic i2c_start();
    tb_sda_low = 1'b0;
    wcyc(HALF);
    release_scl();
    wcyc(HALF);
    tb_sda_low = 1'b1;
    wcyc(HALF);
    tb_scl_low = 1'b1;
    wcyc(HALF);
  endtask

  task automatic i2c_stop();
    tb_sda_low = 1'b1;
    wcyc(HALF);
    release_scl();
    wcyc(HALF);
    tb_sda_low = 1'b0;
    wcyc(HALF);
  endtask

  task automatic clk_bit(input bit bout, output bit bin);
    tb_sda_low = !bout;
    wcyc(HALF);
    release_scl();
    wcyc(HALF / 2);
    bin = sda_bus;
    wcyc(HALF / 2);
    tb_scl_low = 1'b1;
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic read_byte(input bit ack, output logic [7:0] b);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
    clk_bit(!ack, r);
  endtask

  task automatic write_regs(input logic [7:0] addr, input int n);
    bit a;
    i2c_start();
    write_byte(8'h1C, a); chk("R4 addr ack", a, 1);
    write_byte(addr, a);  chk("R4 index ack", a, 1);
    for (int i = 0; i < n; i++) begin
      write_byte(wbuf[i], a);
      chk("R4 data ack", a, 1);
    end
    i2c_stop();
  endtask

  task automatic read_regs(input logic [7:0] addr, input int n);
    bit a;
    i2c_start();
    write_byte(8'h1C, a); chk("R2 write addr ack", a, 1);
    write_byte(addr, a);  chk("R4 index ack", a, 1);
    i2c_start();
    write_byte(8'h1D, a); chk("R2 read addr ack", a, 1);
    for (int i = 0; i < n; i++) read_byte(i < n - 1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic push_sample(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    @(negedge clk);
    raw_x = x; raw_y = y; raw_z = z;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    wcyc(4);
  endtask

  function automatic logic [7:0] model_byte(input int a);
    if (a >= 1 && a <= 6) return (a % 2 == 1) ? m_rdg[(a-1)/2][15:8] : m_rdg[(a-1)/2][7:0];
    if (a >= 9 && a <= 14) return (a % 2 == 1) ? m_ofs[(a-9)/2][15:8] : m_ofs[(a-9)/2][7:0];
    return 8'h00;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit a;
    logic [15:0] sx [3];
    logic [15:0] so [3];
    for (int i = 0; i < 3; i++) begin m_ofs[i] = '0; m_rdg[i] = '0; end
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);

    // R1: reset state
    chk("R1 drdy", drdy_irq, 0);
    chk("R1 scl drive", dut_scl_low, 0);
    chk("R1 sda drive", dut_sda_low, 0);
    read_regs(8'h00, 15);
    for (int i = 0; i < 15; i++) chk("R1 R5 reset byte", rbuf[i], 8'h00);

    // R2 / R10: full address sweep with write bit
    for (int ad = 0; ad < 128; ad++) begin
      stretches = 0;
      i2c_start();
      write_byte({ad[6:0], 1'b0}, a);
      i2c_stop();
      chk("R2 address ack", a, (ad == 14) ? 1 : 0);
      chk("R10 stretch count", stretches, (ad == 14) ? 1 : 0);
    end

    // R3: mismatched address followed by would-be register write
    i2c_start();
    write_byte(8'h1E, a); chk("R3 no ack", a, 0);
    write_byte(8'h09, a); chk("R3 ignored byte", a, 0);
    write_byte(8'h5A, a); chk("R3 ignored byte", a, 0);
    i2c_stop();
    read_regs(8'h09, 1);
    chk("R3 offset untouched", rbuf[0], 8'h00);

    // R4 / R10: offset burst write and read back
    m_ofs[0] = 16'h1234; m_ofs[1] = 16'hABCD; m_ofs[2] = 16'h0F0E;
    for (int i = 0; i < 6; i++) wbuf[i] = model_byte(9 + i);
    stretches = 0;
    write_regs(8'h09, 6);
    chk("R10 write stretches", stretches, 8);
    read_regs(8'h09, 6);
    for (int i = 0; i < 6; i++) chk("R4 offset readback", rbuf[i], model_byte(9 + i));

    // R5: writes to reading registers are ignored
    wbuf[0] = 8'hEE; wbuf[1] = 8'h77;
    write_regs(8'h03, 2);
    read_regs(8'h03, 2);
    chk("R5 read-only", rbuf[0], 8'h00);
    chk("R5 read-only", rbuf[1], 8'h00);

    // R6 / R7 / R9: correction sweep including wrap corners
    for (int k = 0; k < 8; k++) begin
      if (k == 0) begin
        so[0] = 16'h0001; so[1] = 16'hFFFF; so[2] = 16'h8000;
        sx[0] = 16'h8000; sx[1] = 16'h0000; sx[2] = 16'h7FFF;
      end else begin
        for (int ax = 0; ax < 3; ax++) begin
          so[ax] = 16'(k * 16'h2345 + ax * 16'h1111) ^ 16'h8421;
          sx[ax] = 16'(k * 16'h6B1D + ax * 16'h0F0F);
        end
      end
      for (int ax = 0; ax < 3; ax++) m_ofs[ax] = so[ax];
      for (int i = 0; i < 6; i++) wbuf[i] = model_byte(9 + i);
      write_regs(8'h09, 6);
      push_sample(sx[0], sx[1], sx[2]);
      for (int ax = 0; ax < 3; ax++) m_rdg[ax] = 16'(sx[ax] - so[ax]);
      chk("R7 drdy set", drdy_irq, 1);
      stretches = 0;
      read_regs(8'h01, 5);
      if (k == 0) chk("R10 read stretches", stretches, 7);
      for (int i = 0; i < 5; i++) chk("R6 R9 corrected byte", rbuf[i], model_byte(1 + i));
      chk("R7 drdy held", drdy_irq, 1);
      read_regs(8'h06, 1);
      chk("R6 corrected low z", rbuf[0], model_byte(6));
      chk("R7 drdy cleared", drdy_irq, 0);
    end

    // R8: sample during a burst that began at 0x01
    push_sample(16'h1111, 16'h2222, 16'h3333);
    for (int ax = 0; ax < 3; ax++) sx[ax] = m_rdg[ax];
    m_rdg[0] = 16'(16'h1111 - m_ofs[0]);
    m_rdg[1] = 16'(16'h2222 - m_ofs[1]);
    m_rdg[2] = 16'(16'h3333 - m_ofs[2]);
    i2c_start();
    write_byte(8'h1C, a);
    write_byte(8'h01, a);
    i2c_start();
    write_byte(8'h1D, a);
    read_byte(1'b1, rbuf[0]);
    read_byte(1'b1, rbuf[1]);
    push_sample(16'h4444, 16'h5555, 16'h6666);
    for (int i = 2; i < 6; i++) read_byte(i < 5, rbuf[i]);
    i2c_stop();
    for (int i = 0; i < 6; i++) chk("R8 coherent burst", rbuf[i], model_byte(1 + i));
    wcyc(4);
    chk("R8 deferred publish drdy", drdy_irq, 1);
    m_rdg[0] = 16'(16'h4444 - m_ofs[0]);
    m_rdg[1] = 16'(16'h5555 - m_ofs[1]);
    m_rdg[2] = 16'(16'h6666 - m_ofs[2]);
    read_regs(8'h01, 6);
    for (int i = 0; i < 6; i++) chk("R8 new sample", rbuf[i], model_byte(1 + i));

    // R11: START in the middle of a data byte
    begin
      bit r;
      i2c_start();
      write_byte(8'h1C, a);
      write_byte(8'h0A, a);
      for (int i = 0; i < 4; i++) clk_bit(1'b0, r);
      i2c_start();
      write_byte(8'h1D, a);
      chk("R11 restart addr ack", a, 1);
      read_byte(1'b0, rbuf[0]);
      i2c_stop();
      chk("R11 partial byte dropped", rbuf[0], model_byte(10));
      // R11: STOP in the middle of a data byte
      i2c_start();
      write_byte(8'h1C, a);
      write_byte(8'h0B, a);
      for (int i = 0; i < 3; i++) clk_bit(1'b0, r);
      i2c_stop();
      read_regs(8'h0B, 1);
      chk("R11 stop abort", rbuf[0], model_byte(11));
    end

    // R12 is watched by the bound checker throughout
    chk("R1 idle drives", {dut_scl_low, dut_sda_low}, 2'b00);
    finish_run();
  end

endmodule